// File: doc/BRIEF.md
# Flash Verify-Read Wait-State Unit

This unit sits on the read path between a flash array and the system bus. A read request starts an access that lasts a programmable number of clocks. At the end of the access the unit gives a one-cycle data-valid strobe together with the read data for every 32-bit word of the flash row. In verify-read mode the latency comes from a 5-bit wait-state input. In normal mode it comes from a separate default latency input, and the array data passes through unchanged.

Compare-read mode is meant for checking an erase. The unit does not return the array contents. It returns a short pass/fail code built from every data bit and every ECC bit of the row. A fully erased row (all bits 1) gives a fixed marker pattern. A row with any bit at 0 reads back as all zeros. Compare-read is honoured only while verify-read is also enabled.

The unit samples all of its inputs on the clock edge that accepts a request. Changes to the inputs later in the access have no effect on that access.

Top module: `fvr_wait_unit`

## Requirements
- R1: With `vread_en_i`=1, a request accepted at rising edge E makes `valid_o` rise at edge E+`ws_i` and stay high for one cycle, so the access lasts `ws_i`+1 clocks (0..31 wait states).
- R2: With `vread_en_i`=0, the latency follows R1 but uses `dflt_ws_i`, and `ws_i` is ignored.
- R3: Outside compare-read mode, word k of `rdata_o` (bits 32k+31..32k, with word 0 in bits 31:0) equals word k of `row_i` as sampled at acceptance.
- R4: `cread_en_i`=1 with `vread_en_i`=0 has no effect: data passes through raw.
- R5: In compare-read mode (both enables 1), if all 128 row bits and all 8 ECC bits are 1, word 0 reads 0x00000001 and words 1..3 read 0x00010000.
- R6: In compare-read mode, if any row bit or any ECC bit is 0, all four words read 0x00000000.
- R7: A request is accepted only when the unit is idle or in the valid cycle of the current access. Requests at other times are ignored. Data, mode and latency are taken only at acceptance.
- R8: `rdata_o` is all zeros whenever `valid_o` is low.
- R9: During and right after synchronous reset, `valid_o` is 0 and no access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Read request |
| row_i | input | 128 | Raw flash row, four 32-bit words |
| ecc_i | input | 8 | ECC bits of the row |
| ws_i | input | 5 | Wait states in verify-read mode |
| dflt_ws_i | input | 5 | Wait states in normal mode |
| vread_en_i | input | 1 | Verify-read enable |
| cread_en_i | input | 1 | Compare-read enable (needs verify-read) |
| valid_o | output | 1 | One-cycle data-valid strobe |
| rdata_o | output | 128 | Read data, four 32-bit words |

## Verification
The data path is tried with four kinds of row:
- Random rows in verify and normal mode, which separate raw pass-through from any word reordering.
- An all-ones row with all-ones ECC, which must give the marker pattern.
- An all-ones row with a single cleared data bit.
- An all-ones row with only the ECC cleared, which shows that the ECC field takes part in the check.

Latency is tried at 0, 1, 5 and 31 wait states in verify mode and at a distinct default in normal mode, which tells which latency source was chosen. A held request and inputs that change during an access test acceptance and sampling.

// File: rtl/fvr_pkg.sv
package fvr_pkg;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 4;
    localparam int ECC_W     = 8;
    localparam int WS_W      = 5;

    typedef enum logic [1:0] {
        RD_RAW     = 2'd0,
        RD_VERIFY  = 2'd1,
        RD_COMPARE = 2'd2
    } rd_mode_e;

    localparam int PASS_HI_BIT = 16;

    function automatic rd_mode_e pick_mode(input logic vread, input logic cread);
        if (!vread)     return RD_RAW;
        else if (cread) return RD_COMPARE;
        else            return RD_VERIFY;
    endfunction
endpackage

// File: rtl/fvr_wait_ctr.sv
module fvr_wait_ctr #(
    parameter int WS_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_i,
    input  logic [WS_W-1:0] load_i,
    output logic            accept_o,
    output logic            busy_o,
    output logic            last_o,
    output logic [WS_W-1:0] cnt_o
);
    logic            busy_q;
    logic [WS_W-1:0] cnt_q;
    logic            at_end;

    assign at_end   = busy_q && (cnt_q == '0);
    assign accept_o = req_i && (!busy_q || at_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (accept_o) begin
            busy_q <= 1'b1;
            cnt_q  <= load_i;
        end else if (at_end) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign last_o = at_end;
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/fvr_row_shaper.sv
module fvr_row_shaper
    import fvr_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    parameter int ECC_W     = 8
) (
    input  logic [WORD_W*NUM_WORDS-1:0] row_i,
    input  logic [ECC_W-1:0]            ecc_i,
    input  rd_mode_e                    mode_i,
    output logic [WORD_W*NUM_WORDS-1:0] row_o
);
    localparam logic [WORD_W-1:0] MARK_LOW  = WORD_W'(1);
    localparam logic [WORD_W-1:0] MARK_HIGH = WORD_W'(1) << PASS_HI_BIT;

    logic all_set;
    assign all_set = (&row_i) && (&ecc_i);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] mark;
        if (w == 0) begin : g_low
            assign mark = all_set ? MARK_LOW : '0;
        end else begin : g_high
            assign mark = all_set ? MARK_HIGH : '0;
        end
        assign row_o[w*WORD_W +: WORD_W] =
            (mode_i == RD_COMPARE) ? mark : row_i[w*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/fvr_wait_unit.sv
module fvr_wait_unit
    import fvr_pkg::*;
#(
    parameter int WORD_W    = fvr_pkg::WORD_W,
    parameter int NUM_WORDS = fvr_pkg::NUM_WORDS,
    parameter int ECC_W     = fvr_pkg::ECC_W,
    parameter int WS_W      = fvr_pkg::WS_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_i,
    input  logic [WORD_W*NUM_WORDS-1:0] row_i,
    input  logic [ECC_W-1:0]            ecc_i,
    input  logic [WS_W-1:0]             ws_i,
    input  logic [WS_W-1:0]             dflt_ws_i,
    input  logic                        vread_en_i,
    input  logic                        cread_en_i,
    output logic                        valid_o,
    output logic [WORD_W*NUM_WORDS-1:0] rdata_o
);
    localparam int ROW_W = WORD_W * NUM_WORDS;

    rd_mode_e          mode_now;
    rd_mode_e          mode_q;
    logic [WS_W-1:0]   lat_sel;
    logic              accept;
    logic              busy;
    logic              last;
    logic [WS_W-1:0]   cnt;
    logic [ROW_W-1:0]  shaped;
    logic [ROW_W-1:0]  data_q;

    assign mode_now = pick_mode(vread_en_i, cread_en_i);
    assign lat_sel  = vread_en_i ? ws_i : dflt_ws_i;

    fvr_wait_ctr #(.WS_W(WS_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req_i),
        .load_i   (lat_sel),
        .accept_o (accept),
        .busy_o   (busy),
        .last_o   (last),
        .cnt_o    (cnt)
    );

    fvr_row_shaper #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .ECC_W     (ECC_W)
    ) u_shaper (
        .row_i  (row_i),
        .ecc_i  (ecc_i),
        .mode_i (mode_now),
        .row_o  (shaped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            mode_q <= RD_RAW;
        end else if (accept) begin
            data_q <= shaped;
            mode_q <= mode_now;
        end
    end

    assign valid_o = last;
    assign rdata_o = last ? data_q : '0;
endmodule

// File: rtl/fvr_wait_unit_chk.sv
module fvr_wait_unit_chk
    import fvr_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    parameter int WS_W      = 5
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        req_i,
    input logic                        valid_o,
    input logic [WORD_W*NUM_WORDS-1:0] rdata_o,
    input logic                        busy,
    input logic [WS_W-1:0]             cnt,
    input logic [WORD_W*NUM_WORDS-1:0] data_q,
    input rd_mode_e                    mode_q
);
    logic [WORD_W*NUM_WORDS-1:0] mark_row;
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_mark
        assign mark_row[w*WORD_W +: WORD_W] =
            (w == 0) ? WORD_W'(1) : (WORD_W'(1) << PASS_HI_BIT);
    end

    // R1 / R2: the wait count steps down by one each clock of an access
    a_r1_count_down: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));

    // R7: captured data and mode do not move during the access
    a_r7_hold_capture: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> ($stable(data_q) && $stable(mode_q)));

    // R5 / R6: the compare result is either all zeros or the marker row
    a_r5_compare_shape: assert property (@(posedge clk) disable iff (rst)
        (valid_o && mode_q == RD_COMPARE) |-> (rdata_o == '0 || rdata_o == mark_row));

    // R1: the strobe lasts one cycle unless a new request is accepted
    a_r1_single_strobe: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !req_i) |=> !valid_o);

    // R9: no strobe in the first cycle after reset
    a_r9_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !valid_o);
endmodule

bind fvr_wait_unit fvr_wait_unit_chk #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS),
    .WS_W      (WS_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .valid_o (valid_o),
    .rdata_o (rdata_o),
    .busy    (busy),
    .cnt     (cnt),
    .data_q  (data_q),
    .mode_q  (mode_q)
);

// File: tb/fvr_wait_unit_bench.sv
module fvr_wait_unit_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req = 1'b0;
    logic [127:0] row = '0;
    logic [7:0]   ecc = '0;
    logic [4:0]   ws = '0;
    logic [4:0]   dflt = '0;
    logic         vread = 1'b0;
    logic         cread = 1'b0;
    logic         valid;
    logic [127:0] rdata;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_tag = "R9";
    bit    done    = 1'b0;

    always #10 clk = ~clk;

    fvr_wait_unit u_fvr_wait_unit (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .row_i      (row),
        .ecc_i      (ecc),
        .ws_i       (ws),
        .dflt_ws_i  (dflt),
        .vread_en_i (vread),
        .cread_en_i (cread),
        .valid_o    (valid),
        .rdata_o    (rdata)
    );

    function automatic logic [127:0] expect_row(logic [127:0] r, logic [7:0] e, logic v, logic c);
        if (v && c) begin
            if (r == {128{1'b1}} && e == 8'hFF)
                return {32'h0001_0000, 32'h0001_0000, 32'h0001_0000, 32'h0000_0001};
            return '0;
        end
        return r;
    endfunction

    // behavioural reference: one pending access, countdown as an integer
    bit           m_busy = 1'b0;
    int           m_left = 0;
    logic [127:0] m_data = '0;

    always @(posedge clk) begin
        bit take;
        if (rst) begin
            m_busy = 1'b0;
            m_left = 0;
        end else begin
            take = req && (!m_busy || m_left == 0);
            if (m_busy) begin
                if (m_left == 0) m_busy = 1'b0;
                else             m_left = m_left - 1;
            end
            if (take) begin
                m_busy = 1'b1;
                m_left = vread ? int'(ws) : int'(dflt);
                m_data = expect_row(row, ecc, vread, cread);
            end
        end
    end

    always @(negedge clk) begin
        logic         e_valid;
        logic [127:0] e_data;
        if (!done) begin
            e_valid = m_busy && m_left == 0;
            e_data  = e_valid ? m_data : '0;
            n_tests++;
            if (valid !== e_valid || rdata !== e_data) begin
                n_fail++;
                $display("FAIL %s (R8 when idle): valid=%0b rdata=%h expected valid=%0b rdata=%h",
                         cur_tag, valid, rdata, e_valid, e_data);
            end
        end
    end

    task automatic access(input logic [127:0] r, input logic [7:0] e, input logic [4:0] w,
                          input logic [4:0] d, input logic v, input logic c, input string tag);
        int lat;
        @(negedge clk);
        cur_tag = tag;
        row = r; ecc = e; ws = w; dflt = d; vread = v; cread = c; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        // R7: disturb every input after acceptance
        row = ~r; ecc = ~e; ws = ~w; dflt = ~d; vread = ~v; cread = ~c;
        lat = v ? int'(w) : int'(d);
        repeat (lat + 1) @(negedge clk);
    endtask

    function automatic logic [127:0] rnd_row();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        logic [127:0] ones;
        ones = {128{1'b1}};
        repeat (3) @(negedge clk);
        // R9: reset state
        n_tests++;
        if (valid !== 1'b0 || rdata !== '0) begin
            n_fail++;
            $display("FAIL R9: valid=%0b rdata=%h expected 0 and 0", valid, rdata);
        end
        rst = 1'b0;

        // R1 and R3: verify mode at several latencies
        access(rnd_row(), 8'h5A, 5'd0,  5'd9, 1'b1, 1'b0, "R1");
        access(rnd_row(), 8'h11, 5'd1,  5'd9, 1'b1, 1'b0, "R1");
        access(rnd_row(), 8'h22, 5'd5,  5'd2, 1'b1, 1'b0, "R3");
        access(rnd_row(), 8'h33, 5'd31, 5'd2, 1'b1, 1'b0, "R1");
        // R2: normal mode uses the default latency
        access(rnd_row(), 8'h44, 5'd7,  5'd3, 1'b0, 1'b0, "R2");
        access(rnd_row(), 8'h44, 5'd0,  5'd12, 1'b0, 1'b0, "R2");
        // R4: compare without verify passes raw data
        access(ones, 8'hFF, 5'd2, 5'd4, 1'b0, 1'b1, "R4");
        access(rnd_row(), 8'h00, 5'd2, 5'd1, 1'b0, 1'b1, "R4");
        // R5: fully erased row
        access(ones, 8'hFF, 5'd3, 5'd1, 1'b1, 1'b1, "R5");
        access(ones, 8'hFF, 5'd0, 5'd1, 1'b1, 1'b1, "R5");
        // R6: one cleared bit in data, then only in ECC
        access(ones ^ (128'd1 << 77), 8'hFF, 5'd2, 5'd1, 1'b1, 1'b1, "R6");
        access(ones, 8'h7F, 5'd2, 5'd1, 1'b1, 1'b1, "R6");
        access(ones ^ 128'd1, 8'hFF, 5'd1, 5'd1, 1'b1, 1'b1, "R6");

        // R7: held request during a 4-clock access, inputs changing each cycle
        @(negedge clk);
        cur_tag = "R7";
        vread = 1'b1; cread = 1'b0; ws = 5'd3; req = 1'b1;
        for (int i = 0; i < 12; i++) begin
            row = rnd_row();
            @(negedge clk);
        end
        // R1: back-to-back single-clock accesses
        cur_tag = "R1";
        ws = 5'd0;
        for (int i = 0; i < 5; i++) begin
            row = rnd_row();
            @(negedge clk);
        end
        req = 1'b0;
        repeat (3) @(negedge clk);

        // R9: reset in the middle of an access
        cur_tag = "R9";
        access(rnd_row(), 8'h00, 5'd20, 5'd1, 1'b1, 1'b0, "R9");
        @(negedge clk);
        req = 1'b1; ws = 5'd10; vread = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (12) @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (%s): run did not end, expected completion", cur_tag);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule